// File: doc/BRIEF.md
# Decimal Digit Shifter with Spill Writeback

This block moves the decimal digits of a four-digit BCD word left or right by zero to four places. The amount and the direction come from one signed immediate digit. Left shifts multiply by a power of ten and right shifts divide by one. Vacated digit positions are filled with zero. Digits pushed past either end of the word are not lost. They are collected into a second word, the spill, right-aligned and with zeros above them.

An operation enters through a valid/ready handshake. It carries the source word, the shift digit, the source register index (the register whose value is replaced by the shifted word) and the destination register index (the register that receives the spill). The block then issues its results to the register file as a sequence of write beats on a valid/ready write port. The shifted word always goes first. A second beat carries the spill, unless the destination is register 0, whose value is fixed at zero, or is the same register as the source. In that second case the shifted word wins.

Back-pressure rules: `in_ready` is high only while no operation is in progress, and an operation is taken in the cycle where `in_valid` and `in_ready` are both high. A write beat completes in the cycle where `wb_valid` and `wb_ready` are both high. While `wb_ready` is low, the beat's address and data are held unchanged. `done` pulses for one cycle once the last beat of an operation has been taken. Both results also stay visible on `res_word` and `spill_word` until the next operation is accepted.

Top module: `decimal_spill_shifter`

## Requirements
- R1: Shift digit values 1 to 4 shift the word left by that many digits, and the low digit positions become zero. For example, 4321 with shift digit 2 gives 2100.
- R2: On a left shift, the digits pushed out at the top appear in the spill in their original order, in the lowest digit positions, with zeros above. For example, 4321 shifted left by 2 spills 0043, and shifting left by 4 spills the whole word.
- R3: Shift digit values 9, 8, 7 and 6 shift right by 1, 2, 3 and 4 digits. The upper positions become zero, and the digits dropped at the bottom form the spill, kept in their original positions with zeros above. For example, 4321 with shift digit 9 gives 0432 with spill 0001.
- R4: Shift digit 0, the out-of-range value 5 (which would mean minus five), and the non-decimal codes 10 to 15 all act as a zero shift. The result equals the source word and the spill is 0000.
- R5: `in_ready` is high exactly when no operation is in progress. `res_word` and `spill_word` change only in the cycle after an operation is accepted, and an `in_valid` raised during an operation has no effect.
- R6: The first write beat carries the source index with the shifted word. The second beat, when present, carries the destination index with the spill. While a beat waits for `wb_ready`, it stays valid with its address and data unchanged.
- R7: When the destination index is 0, only the shifted-word beat is issued and the spill is discarded.
- R8: When the destination index equals the source index, only one beat is issued, and it carries the shifted word.
- R9: `done` is high for exactly one cycle: the cycle after the last write beat of an operation is taken. `in_ready` is high in that same cycle.
- R10: After reset, `in_ready` is 1, while `wb_valid`, `done`, `res_word` and `spill_word` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block can take an operation (idle) |
| in_word | input | 16 | Source word, four BCD digits |
| in_shift | input | 4 | Signed shift digit (0..4 left, 9..6 right by 1..4) |
| in_src_idx | input | 4 | Register index that receives the shifted word |
| in_dst_idx | input | 4 | Register index that receives the spill |
| wb_valid | output | 1 | A register write beat is offered |
| wb_ready | input | 1 | The register file takes the beat |
| wb_addr | output | 4 | Register index of the write beat |
| wb_data | output | 16 | Data of the write beat |
| res_word | output | 16 | Shifted word of the last accepted operation |
| spill_word | output | 16 | Spill word of the last accepted operation |
| done | output | 1 | One-cycle pulse after the final write beat |

## Verification
The hardest situation to reach from the ports is a second operation offered while the write sequence of the current one is stalled. This needs a stalled write port and a new `in_valid` at the same time. The stimulus holds `wb_ready` low for several cycles on a two-beat operation and raises `in_valid` with a different word during the stall. It then confirms that `res_word`, the held beat and the later spill beat all still belong to the first operation. It also lowers `in_valid` before the idle cycle in which `done` pulses, so no unintended accept happens there.

// File: rtl/dss_pkg.sv
package dss_pkg;
  localparam int RADIX = 10;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SRC   = 2'd1,
    SEQ_SPILL = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dss_amount_dec.sv
module dss_amount_dec #(
  parameter int DIG_W = 4,
  parameter int MAX_SH = 4,
  parameter int AMT_W = 3
) (
  input  logic [DIG_W-1:0] code,
  output logic             go_left,
  output logic [AMT_W-1:0] amount
);
  import dss_pkg::*;

  localparam int RIGHT_LO = RADIX - MAX_SH;

  int code_i;

  always_comb begin
    code_i  = int'(code);
    go_left = 1'b1;
    amount  = '0;
    if (code_i <= MAX_SH) begin
      amount = AMT_W'(code_i);
    end else if (code_i >= RIGHT_LO && code_i < RADIX) begin
      go_left = 1'b0;
      amount  = AMT_W'(RADIX - code_i);
    end
  end
endmodule

// File: rtl/dss_shift_core.sv
module dss_shift_core #(
  parameter int NDIG = 4,
  parameter int DIG_W = 4,
  parameter int MAX_SH = 4,
  parameter int AMT_W = 3
) (
  input  logic [NDIG*DIG_W-1:0] word,
  input  logic                  go_left,
  input  logic [AMT_W-1:0]      amount,
  output logic [NDIG*DIG_W-1:0] shifted,
  output logic [NDIG*DIG_W-1:0] spill
);
  logic [DIG_W-1:0] dig [NDIG];

  for (genvar g = 0; g < NDIG; g++) begin : g_unpack
    assign dig[g] = word[g*DIG_W +: DIG_W];
  end

  for (genvar i = 0; i < NDIG; i++) begin : g_digit
    logic [DIG_W-1:0] sh_d;
    logic [DIG_W-1:0] sp_d;

    always_comb begin
      sh_d = '0;
      sp_d = '0;
      for (int n = 0; n <= MAX_SH; n++) begin
        if (int'(amount) == n) begin
          if (go_left) begin
            if (i >= n) sh_d = dig[i-n];
            if (i < n)  sp_d = dig[NDIG-n+i];
          end else begin
            if (i + n < NDIG) sh_d = dig[i+n];
            if (i < n)        sp_d = dig[i];
          end
        end
      end
    end

    assign shifted[i*DIG_W +: DIG_W] = sh_d;
    assign spill[i*DIG_W +: DIG_W]   = sp_d;
  end
endmodule

// File: rtl/dss_wb_seq.sv
module dss_wb_seq #(
  parameter int WORD_W = 16,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [WORD_W-1:0] shifted_q,
  input  logic [WORD_W-1:0] spill_q,
  input  logic              wb_ready,
  output logic              idle,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_addr,
  output logic [WORD_W-1:0] wb_data,
  output logic [IDX_W-1:0]  cur_src,
  output logic [IDX_W-1:0]  cur_dst,
  output logic              done
);
  import dss_pkg::*;

  seq_state_e state_q, state_d;
  logic       done_d;
  logic       need_spill;

  assign need_spill = (cur_dst != '0) && (cur_dst != cur_src);

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      SEQ_IDLE:  if (start) state_d = SEQ_SRC;
      SEQ_SRC: begin
        if (wb_ready) begin
          if (need_spill) begin
            state_d = SEQ_SPILL;
          end else begin
            state_d = SEQ_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      SEQ_SPILL: begin
        if (wb_ready) begin
          state_d = SEQ_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done    <= 1'b0;
      cur_src <= '0;
      cur_dst <= '0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
      if (start && state_q == SEQ_IDLE) begin
        cur_src <= src_idx;
        cur_dst <= dst_idx;
      end
    end
  end

  assign idle     = (state_q == SEQ_IDLE);
  assign wb_valid = (state_q == SEQ_SRC) || (state_q == SEQ_SPILL);
  assign wb_addr  = (state_q == SEQ_SPILL) ? cur_dst : cur_src;
  assign wb_data  = (state_q == SEQ_SPILL) ? spill_q : shifted_q;
endmodule

// File: rtl/decimal_spill_shifter.sv
module decimal_spill_shifter #(
  parameter int NDIG = 4,
  parameter int DIG_W = 4,
  parameter int IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [NDIG*DIG_W-1:0] in_word,
  input  logic [DIG_W-1:0]      in_shift,
  input  logic [IDX_W-1:0]      in_src_idx,
  input  logic [IDX_W-1:0]      in_dst_idx,
  output logic                  wb_valid,
  input  logic                  wb_ready,
  output logic [IDX_W-1:0]      wb_addr,
  output logic [NDIG*DIG_W-1:0] wb_data,
  output logic [NDIG*DIG_W-1:0] res_word,
  output logic [NDIG*DIG_W-1:0] spill_word,
  output logic                  done
);
  localparam int WORD_W = NDIG * DIG_W;
  localparam int MAX_SH = NDIG;
  localparam int AMT_W  = $clog2(MAX_SH + 1);

  logic              go_left;
  logic [AMT_W-1:0]  amount;
  logic [WORD_W-1:0] sh_comb, sp_comb;
  logic [WORD_W-1:0] res_q, spill_q;
  logic              accept;
  logic              idle;
  logic [IDX_W-1:0]  cur_src, cur_dst;

  dss_amount_dec #(.DIG_W(DIG_W), .MAX_SH(MAX_SH), .AMT_W(AMT_W)) u_dec (
    .code    (in_shift),
    .go_left (go_left),
    .amount  (amount)
  );

  dss_shift_core #(.NDIG(NDIG), .DIG_W(DIG_W), .MAX_SH(MAX_SH), .AMT_W(AMT_W)) u_core (
    .word    (in_word),
    .go_left (go_left),
    .amount  (amount),
    .shifted (sh_comb),
    .spill   (sp_comb)
  );

  assign accept = in_valid && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      spill_q <= '0;
    end else if (accept) begin
      res_q   <= sh_comb;
      spill_q <= sp_comb;
    end
  end

  dss_wb_seq #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .src_idx   (in_src_idx),
    .dst_idx   (in_dst_idx),
    .shifted_q (res_q),
    .spill_q   (spill_q),
    .wb_ready  (wb_ready),
    .idle      (idle),
    .wb_valid  (wb_valid),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data),
    .cur_src   (cur_src),
    .cur_dst   (cur_dst),
    .done      (done)
  );

  assign in_ready   = idle;
  assign res_word   = res_q;
  assign spill_word = spill_q;
endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
  parameter int WORD_W = 16,
  parameter int DIG_W = 4,
  parameter int IDX_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_word,
  input logic [DIG_W-1:0]  in_shift,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [IDX_W-1:0]  wb_addr,
  input logic [WORD_W-1:0] wb_data,
  input logic [WORD_W-1:0] res_word,
  input logic [WORD_W-1:0] spill_word,
  input logic [IDX_W-1:0]  cur_src,
  input logic [IDX_W-1:0]  cur_dst,
  input logic              done
);
  assert_beat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !wb_valid);

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(res_word) && $stable(spill_word));

  assert_zero_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_shift == 4'd0 || in_shift == 4'd5)
    |=> spill_word == '0 && res_word == $past(in_word));

  assert_no_spill_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready && cur_dst == '0 |=> !wb_valid && done);

  assert_same_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready && cur_dst == cur_src |=> !wb_valid && done);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready ##1 !done);
endmodule

bind decimal_spill_shifter dss_checker #(
  .WORD_W(NDIG*DIG_W), .DIG_W(DIG_W), .IDX_W(IDX_W)
) u_dss_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_word    (in_word),
  .in_shift   (in_shift),
  .wb_valid   (wb_valid),
  .wb_ready   (wb_ready),
  .wb_addr    (wb_addr),
  .wb_data    (wb_data),
  .res_word   (res_word),
  .spill_word (spill_word),
  .cur_src    (cur_src),
  .cur_dst    (cur_dst),
  .done       (done)
);

// File: tb/tb_decimal_spill_shifter.sv
module tb_decimal_spill_shifter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic [3:0]  in_shift = '0;
  logic [3:0]  in_src_idx = '0;
  logic [3:0]  in_dst_idx = '0;
  logic        wb_valid;
  logic        wb_ready = 1'b0;
  logic [3:0]  wb_addr;
  logic [15:0] wb_data;
  logic [15:0] res_word;
  logic [15:0] spill_word;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  decimal_spill_shifter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_shift(in_shift), .in_src_idx(in_src_idx),
    .in_dst_idx(in_dst_idx), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_addr(wb_addr), .wb_data(wb_data), .res_word(res_word),
    .spill_word(spill_word), .done(done)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] to_bcd(int v);
    logic [15:0] b;
    int t;
    t = v;
    for (int i = 0; i < 4; i++) begin
      b[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return b;
  endfunction

  function automatic int pow10(int n);
    int p;
    p = 1;
    for (int i = 0; i < n; i++) p = p * 10;
    return p;
  endfunction

  // Arithmetic model: left n -> (v*10^n) mod 10^4, spill v / 10^(4-n);
  // right n -> v / 10^n, spill v mod 10^n; anything else is a zero shift.
  task automatic model(int v, int code, output int r, output int s);
    if (code >= 1 && code <= 4) begin
      r = (v * pow10(code)) % 10000;
      s = v / pow10(4 - code);
    end else if (code >= 6 && code <= 9) begin
      r = v / pow10(10 - code);
      s = v % pow10(10 - code);
    end else begin
      r = v;
      s = 0;
    end
  endtask

  task automatic run_op(string tag, int val, int code, int src, int dst,
                        int stall, bit poke);
    int er, es, nbeats;
    logic [3:0]  ea;
    logic [15:0] ed;
    model(val, code, er, es);
    nbeats = (dst == 0 || dst == src) ? 1 : 2;
    @(negedge clk);
    chk({tag, " R5 ready before"}, 32'(in_ready), 32'd1);
    in_word = to_bcd(val); in_shift = 4'(code);
    in_src_idx = 4'(src); in_dst_idx = 4'(dst);
    in_valid = 1'b1; wb_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R1/R3 result"}, 32'(res_word), 32'(to_bcd(er)));
    chk({tag, " R2/R3 spill"}, 32'(spill_word), 32'(to_bcd(es)));
    chk({tag, " R5 busy"}, 32'(in_ready), 32'd0);
    for (int b = 0; b < nbeats; b++) begin
      ea = (b == 0) ? 4'(src) : 4'(dst);
      ed = (b == 0) ? to_bcd(er) : to_bcd(es);
      for (int s = 0; s < stall; s++) begin
        if (poke) begin
          in_valid = 1'b1; in_word = 16'h9999; in_shift = 4'd1;
        end
        chk({tag, " R6 stalled valid"}, 32'(wb_valid), 32'd1);
        chk({tag, " R6 stalled addr"}, 32'(wb_addr), 32'(ea));
        chk({tag, " R6 stalled data"}, 32'(wb_data), 32'(ed));
        @(negedge clk);
        if (poke) chk({tag, " R5 ignored input"}, 32'(res_word), 32'(to_bcd(er)));
      end
      in_valid = 1'b0;
      chk({tag, " R6 beat valid"}, 32'(wb_valid), 32'd1);
      chk({tag, " R6 beat addr"}, 32'(wb_addr), 32'(ea));
      chk({tag, " R6 beat data"}, 32'(wb_data), 32'(ed));
      wb_ready = 1'b1;
      @(negedge clk);
      wb_ready = 1'b0;
    end
    chk({tag, " R7/R8/R9 done"}, 32'(done), 32'd1);
    chk({tag, " R7/R8 no extra beat"}, 32'(wb_valid), 32'd0);
    chk({tag, " R9 ready with done"}, 32'(in_ready), 32'd1);
    @(negedge clk);
    chk({tag, " R9 single pulse"}, 32'(done), 32'd0);
    chk({tag, " R5 result held"}, 32'(res_word), 32'(to_bcd(er)));
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R10 in_ready", 32'(in_ready), 32'd1);
    chk("R10 wb_valid", 32'(wb_valid), 32'd0);
    chk("R10 done", 32'(done), 32'd0);
    chk("R10 res", 32'(res_word), 32'd0);
    chk("R10 spill", 32'(spill_word), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_op("R1 R2 left2",   4321, 2,  3, 5, 0, 0);
    run_op("R3 right1",     4321, 9,  1, 2, 0, 0);
    run_op("R2 left4",      1234, 4,  4, 6, 1, 0);
    run_op("R3 right4",     5678, 6,  7, 8, 0, 0);
    run_op("R1 left1",      9087, 1,  2, 9, 0, 0);
    run_op("R3 right3",     2468, 7,  5, 3, 0, 0);
    run_op("R4 code0",      1357, 0,  1, 2, 0, 0);
    run_op("R4 code5",      8642, 5,  3, 4, 0, 0);
    run_op("R4 code12",     1111, 12, 3, 4, 0, 0);
    run_op("R7 dst zero",   4321, 3,  6, 0, 0, 0);
    run_op("R8 same reg",   4321, 8,  7, 7, 1, 0);
    run_op("R5 R6 stall",   9876, 8,  2, 3, 3, 1);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule